// File: doc/BRIEF.md
# Combinational Integer ALU with Signed Compare

This block is the arithmetic and logic stage of a small load/store datapath. It takes two operand words and a four-bit function code, and it returns a result word and an equality flag in the same cycle, with no internal storage. Five plain functions are supported: AND, OR, NOR, addition and subtraction. A sixth, set-on-less-than, reuses the subtractor. The sign bit of the difference is fed back into bit 0 of the result, and every other result bit is cleared.

A single carry-lookahead adder does all the arithmetic. Bit 2 of the function code turns on operand-B negation: B is inverted and the carry-in is forced to one, which gives two's-complement subtraction. Bit 3 inverts operand A, so the NOR code runs through the AND path as (~A)&(~B). A wide NOR over the result drives the equality flag, which a branch unit reads after a subtraction. The block has no state machine: there are no states and no transitions. Each function code is a fixed combinational path.

Top module: `alu_core`

## Requirements
- R1: With function code 4'b0000, result equals A bitwise-AND B.
- R2: With function code 4'b0001, result equals A bitwise-OR B.
- R3: With function code 4'b0010, result equals A plus B modulo 2^32; the carry out of bit 31 is discarded.
- R4: With function code 4'b0110, result equals A minus B modulo 2^32.
- R5: With function code 4'b0111, result bits 31..1 are zero. When A−B does not overflow as a signed 32-bit value, bit 0 is 1 exactly when A is less than B as signed numbers.
- R6: With function code 4'b0111, when A−B overflows as a signed value, bit 0 is the raw bit 31 of the wrapped difference. This is the opposite of the true signed comparison.
- R7: With function code 4'b1100, result equals the bitwise NOR of A and B.
- R8: Any function code other than the six above drives the result to all zeros.
- R9: zero is 1 exactly when all 32 result bits are 0, for every function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| ctrl | input | 4 | Function code; bit 3 inverts A, bit 2 negates B |
| result | output | 32 | Function output |
| zero | output | 1 | High when result is all zeros |

## Verification
The block holds no state, so a wrong internal signal shows at the ports in the same evaluation as the operands that expose it. A broken group-carry term appears as a sum error only when a carry has to cross that group boundary. The bench therefore drives long carry chains, such as all-ones plus one, as well as random words. A miswired negate or invert bit corrupts SUB, SLT and NOR together. A wrong feedback tap shows on SLT only when the operand signs differ or the values are near each other, so those operand pairs are driven directly.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int CTL_W = 4;

    typedef enum logic [CTL_W-1:0] {
        FN_AND = 4'b0000,
        FN_OR  = 4'b0001,
        FN_ADD = 4'b0010,
        FN_SUB = 4'b0110,
        FN_SLT = 4'b0111,
        FN_NOR = 4'b1100
    } alu_fn_e;

    // Position of the operand modifier bits inside the function code
    localparam int BIT_A_INV = 3;
    localparam int BIT_B_NEG = 2;

    function automatic logic fn_known(input logic [CTL_W-1:0] c);
        return (c == FN_AND) || (c == FN_OR) || (c == FN_ADD) ||
               (c == FN_SUB) || (c == FN_SLT) || (c == FN_NOR);
    endfunction
endpackage

// File: rtl/alu_operand_cond.sv
module alu_operand_cond #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         a_inv,
    input  logic         b_neg,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         carry_in
);
    always_comb begin
        a_out    = a_inv ? ~a_in : a_in;
        b_out    = b_neg ? ~b_in : b_in;
        carry_in = b_neg;
    end

    // R4: B negation always comes with a forced carry-in
    always_comb begin
        if (b_neg) begin
            p_neg_carry_r4: assert ((b_out ^ b_in) == {W{1'b1}} && carry_in)
                else $error("p_neg_carry_r4");
        end
    end
endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
    parameter int W  = 32,
    parameter int GW = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum
);
    localparam int NG = W / GW;

    logic [W-1:0]  g_bit, p_bit, c_bit;
    logic [NG-1:0] g_grp, p_grp;
    logic [NG:0]   c_grp;

    assign g_bit = x & y;
    assign p_bit = x ^ y;

    // Group generate / propagate terms
    always_comb begin
        for (int k = 0; k < NG; k++) begin
            logic gacc, pacc;
            gacc = 1'b0;
            pacc = 1'b1;
            for (int j = GW-1; j >= 0; j--) begin
                gacc = gacc | (pacc & g_bit[k*GW+j]);
                pacc = pacc & p_bit[k*GW+j];
            end
            g_grp[k] = gacc;
            p_grp[k] = pacc;
        end
    end

    // Lookahead carries into each group, expanded sum of products
    always_comb begin
        c_grp[0] = cin;
        for (int k = 1; k <= NG; k++) begin
            logic cacc, prod;
            cacc = g_grp[k-1];
            prod = p_grp[k-1];
            for (int j = k-2; j >= 0; j--) begin
                cacc = cacc | (prod & g_grp[j]);
                prod = prod & p_grp[j];
            end
            c_grp[k] = cacc | (prod & cin);
        end
    end

    // Per-bit carries inside each group, from that group's carry-in
    genvar gi;
    generate
        for (gi = 0; gi < NG; gi++) begin : g_group
            always_comb begin
                for (int i = 0; i < GW; i++) begin
                    logic cacc, prod;
                    cacc = 1'b0;
                    prod = 1'b1;
                    for (int j = i-1; j >= 0; j--) begin
                        cacc = cacc | (prod & g_bit[gi*GW+j]);
                        prod = prod & p_bit[gi*GW+j];
                    end
                    c_bit[gi*GW+i] = cacc | (prod & c_grp[gi]);
                end
            end
        end
    endgenerate

    assign sum = p_bit ^ c_bit;

    // R3: the lookahead network must agree with plain modular addition
    always_comb begin
        p_sum_r3: assert (sum == (x + y + {{(W-1){1'b0}}, cin}))
            else $error("p_sum_r3");
    end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    output logic         is_zero
);
    assign is_zero = ~(|value);
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int GW = 4
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [CTL_W-1:0] ctrl,
    output logic [W-1:0]     result,
    output logic             zero
);
    logic [W-1:0] a_c, b_c, sum;
    logic         cin;

    alu_operand_cond #(.W(W)) u_cond (
        .a_in(a), .b_in(b),
        .a_inv(ctrl[BIT_A_INV]), .b_neg(ctrl[BIT_B_NEG]),
        .a_out(a_c), .b_out(b_c), .carry_in(cin)
    );

    alu_cla_adder #(.W(W), .GW(GW)) u_add (
        .x(a_c), .y(b_c), .cin(cin), .sum(sum)
    );

    always_comb begin
        unique case (ctrl)
            FN_AND, FN_NOR: result = a_c & b_c;
            FN_OR:          result = a_c | b_c;
            FN_ADD, FN_SUB: result = sum;
            FN_SLT:         result = {{(W-1){1'b0}}, sum[W-1]};
            default:        result = '0;
        endcase
    end

    alu_zero_detect #(.W(W)) u_zero (.value(result), .is_zero(zero));

    // Checks on port relations
    always_comb begin
        if (ctrl == FN_SLT) begin
            p_slt_upper_r5: assert (result[W-1:1] == '0)
                else $error("p_slt_upper_r5");
        end
        if (ctrl == FN_NOR) begin
            p_nor_disjoint_r7: assert ((result & (a | b)) == '0)
                else $error("p_nor_disjoint_r7");
        end
        if (ctrl == FN_AND) begin
            p_and_subset_r1: assert ((result & ~(a & b)) == '0)
                else $error("p_and_subset_r1");
        end
        if (!fn_known(ctrl)) begin
            p_unknown_clear_r8: assert (result == '0 && zero)
                else $error("p_unknown_clear_r8");
        end
        if (ctrl == FN_SUB && a == b) begin
            p_equal_zero_r9: assert (zero)
                else $error("p_equal_zero_r9");
        end
    end
endmodule

// File: tb/tb_alu_core.sv
module tb_alu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [3:0]  ctrl = '0;
    logic [31:0] result;
    logic        zero;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu_core dut (.a(a), .b(b), .ctrl(ctrl), .result(result), .zero(zero));

    // Behavioural reference model
    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [3:0] c);
        longint d;
        bit lt, ovf;
        case (c)
            4'b0000: return x & y;
            4'b0001: return x | y;
            4'b0010: return x + y;
            4'b0110: return x - y;
            4'b0111: begin
                d   = longint'($signed(x)) - longint'($signed(y));
                lt  = (d < 0);
                ovf = (d > 64'sd2147483647) || (d < -64'sd2147483648);
                return {31'b0, ovf ? !lt : lt};
            end
            4'b1100: return ~(x | y);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b0000: return "R1";
            4'b0001: return "R2";
            4'b0010: return "R3";
            4'b0110: return "R4";
            4'b0111: return "R5";
            4'b1100: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h ctrl=%b got %h expected %h", tag, a, b, ctrl, got, exp);
        end
    endtask

    // Drive after a rising edge, compare at the following falling edge
    task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] c,
                         input string tag);
        logic [31:0] e;
        @(posedge clk); #1;
        a = x; b = y; ctrl = c;
        @(negedge clk);
        e = model(x, y, c);
        check(tag, result, e);
        check("R9", {31'b0, zero}, {31'b0, (e == 32'h0)});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: all-zero inputs give AND of zeros
        check("R1", result, 32'h0);
        check("R9", {31'b0, zero}, 32'h1);
        rst_n = 1'b1;

        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, "R1");
        apply(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, "R2");
        apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, "R3");   // full carry chain, wraps
        apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, "R3");
        apply(32'h0000_0005, 32'h0000_0007, 4'b0110, "R4");
        apply(32'h1234_5678, 32'h1234_5678, 4'b0110, "R9");   // equal operands
        apply(32'hFFFF_FFFE, 32'h0000_0003, 4'b0111, "R5");   // -2 < 3
        apply(32'h0000_0003, 32'hFFFF_FFFE, 4'b0111, "R5");   // 3 > -2
        apply(32'h0000_0009, 32'h0000_0009, 4'b0111, "R5");
        apply(32'h0000_0008, 32'h0000_0009, 4'b0111, "R5");
        // Signed overflow: true result is "less", raw sign says 0
        apply(32'h8000_0000, 32'h0000_0001, 4'b0111, "R6");
        // Signed overflow: true result is "not less", raw sign says 1
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111, "R6");
        apply(32'h0000_0000, 32'h0000_0000, 4'b1100, "R7");
        apply(32'hAAAA_0000, 32'h0000_5555, 4'b1100, "R7");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1000, "R8");
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1111, "R8");
        apply(32'h1234_5678, 32'h0000_0001, 4'b0011, "R8");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  c;
            logic [31:0] x, y;
            c = 4'($urandom_range(0, 15));
            x = $urandom;
            y = (i % 5 == 0) ? x : $urandom;
            if (i % 7 == 0) y = x + 32'(($urandom_range(0, 2))) - 32'd1;
            apply(x, y, c, tag_of(c));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule